// File: doc/BRIEF.md
# Two-Step Register Renamer with Late Physical Binding

This block renames registers for an out-of-order core in two separate steps. At decode, each destination register receives a fresh virtual tag. That tag only expresses dependences. Each source is translated through a logical-to-virtual map. No storage is spent at this point. A physical register is bound to the virtual tag only when the producing instruction writes back. The binding is then recorded in a table indexed by virtual tag. Register storage is therefore held only for the interval in which a value actually exists.

Because storage is handed out late, a write-back can find no register. Two mechanisms cover this case:

- **Reserved pool.** A programmable number of free physical registers is held back, and only the oldest in-flight instruction may draw on them. This prevents deadlock.
- **Steal mode.** When enabled, a starved requester takes the physical register of the youngest younger instruction that holds one. The victim is reported so that it can be re-executed.

If neither mechanism helps, the write-back is refused and the instruction must re-execute.

On commit, the reorder buffer returns two items:

- The overwritten older virtual tag. That tag and its physical register go back to their free lists.
- The committing instruction's own tag. Its value becomes architectural and can no longer be stolen.

Ages are reorder-buffer indices compared relative to the current head, so index wrap-around is handled.

Top module: `vp_renamer`

## Requirements
- R1: After reset, logical register i maps to virtual tag i. That tag is bound to physical register i and reads as ready. Virtual tags 32..63 and physical registers 32..47 are free.
- R2: A decode with `decValid` high and `decStall` low gives the destination the lowest-numbered free virtual tag on `decDstVtag`. The previous mapping appears on `decOldVtag`. From the next cycle, sources naming that logical register return the new tag as not ready.
- R3: When no virtual tag is free, `decStall` is high and the logical map is left unchanged.
- R4: A write-back that may use the free list is granted the lowest-numbered free physical register on `wbPhys`. From the next cycle, a source whose tag is that virtual tag reads ready with that physical index.
- R5: A write-back whose age differs from `robHead` may take a free register only while the free count exceeds `rsvCount`. A write-back whose age equals `robHead` may take one while any register is free.
- R6: A write-back that can neither use the free list nor steal raises `wbRetry` and leaves `wbGrant` low. Exactly one of the two is high for every valid write-back.
- R7: With `stealEn` high and no usable free register, the requester receives the physical register of the holder with the greatest relative age above its own. `victimValid` and `victimVtag` name that holder, which then reads as not ready.
- R8: Relative age is (age − `robHead`) modulo the reorder-buffer depth (64). An entry stored with a numerically small index after the head has wrapped therefore counts as younger.
- R9: A commit frees `cmtOldVtag` and, if that tag was bound, its physical register. Both are reusable from the next cycle. `cmtNewVtag` stops being a steal candidate.
- R10: A tag being committed as `cmtOldVtag` in the same cycle is never chosen as a steal victim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| decValid | input | 1 | Decode rename request |
| decDst | input | 5 | Logical destination register |
| srcA | input | 5 | Logical source A |
| srcB | input | 5 | Logical source B |
| decDstVtag | output | 6 | Virtual tag given to the destination |
| decOldVtag | output | 6 | Previous virtual tag of the destination |
| decStall | output | 1 | No free virtual tag |
| srcAVtag | output | 6 | Virtual tag of source A |
| srcAReady | output | 1 | Source A tag has a physical binding |
| srcAPhys | output | 6 | Physical register of source A |
| srcBVtag | output | 6 | Virtual tag of source B |
| srcBReady | output | 1 | Source B tag has a physical binding |
| srcBPhys | output | 6 | Physical register of source B |
| wbValid | input | 1 | Write-back allocation request |
| wbVtag | input | 6 | Virtual tag being written back |
| wbAge | input | 6 | Reorder-buffer index of the writer |
| robHead | input | 6 | Reorder-buffer index of the oldest instruction |
| rsvCount | input | 4 | Number of reserved physical registers (0..8) |
| stealEn | input | 1 | Enable taking a register from a younger holder |
| wbGrant | output | 1 | Physical register granted |
| wbPhys | output | 6 | Granted physical register |
| wbRetry | output | 1 | Writer must re-execute |
| victimValid | output | 1 | A younger holder lost its register |
| victimVtag | output | 6 | Virtual tag of the victim |
| cmtValid | input | 1 | Commit release |
| cmtOldVtag | input | 6 | Overwritten tag to free |
| cmtNewVtag | input | 6 | Committing instruction's own tag |

## Verification
A commit can free a virtual tag and a physical register in the same cycle in which a decode or a write-back draws from the same free lists. It can also release the very holder that a steal would pick.

The bench provokes the first case by committing while the free lists are empty. In the cycle that follows, it issues a decode and a write-back together. Both must receive exactly the resources that the commit released.

For the second case, the bench commits the only eligible victim in the same cycle as a stealing write-back. The write-back must then be refused with no victim named, since the commit has just freed that register.

// File: rtl/vp_rename_pkg.sv
package vp_rename_pkg;
  parameter int LOG_REGS    = 32;
  parameter int VIRT_TAGS   = 64;
  parameter int PHYS_REGS   = 48;
  parameter int ROB_ENTRIES = 64;
  parameter int RSV_MAX     = 8;

  localparam int LW = $clog2(LOG_REGS);
  localparam int VW = $clog2(VIRT_TAGS);
  localparam int PW = $clog2(PHYS_REGS);
  localparam int AW = $clog2(ROB_ENTRIES);
  localparam int RW = $clog2(RSV_MAX + 1);
  localparam int CW = $clog2(PHYS_REGS + 1);

  typedef logic [LW-1:0] logIdx_t;
  typedef logic [VW-1:0] vtag_t;
  typedef logic [PW-1:0] phys_t;
  typedef logic [AW-1:0] age_t;

  // Update strobes from control to datapath
  typedef struct packed {
    logic    allocV;
    vtag_t   allocVtag;
    logIdx_t allocLog;
    logic    bindP;
    logic    fromFree;
    vtag_t   bindVtag;
    phys_t   bindPhys;
    age_t    bindAge;
    logic    steal;
    vtag_t   victim;
    logic    cmt;
    vtag_t   cmtOld;
    vtag_t   cmtNew;
  } strobe_t;
endpackage

// File: rtl/vp_rename_dp.sv
module vp_rename_dp
  import vp_rename_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  strobe_t                   stb,
  input  logIdx_t                   decDst,
  input  logIdx_t                   srcA,
  input  logIdx_t                   srcB,
  output vtag_t                     decOldVtag,
  output vtag_t                     srcAVtag,
  output logic                      srcAReady,
  output phys_t                     srcAPhys,
  output vtag_t                     srcBVtag,
  output logic                      srcBReady,
  output phys_t                     srcBPhys,
  output logic [VIRT_TAGS-1:0]      freeV,
  output logic [PHYS_REGS-1:0]      freeP,
  output logic [VIRT_TAGS-1:0]      held,
  output logic [VIRT_TAGS-1:0][AW-1:0] virtAge,
  output logic [VIRT_TAGS-1:0][PW-1:0] virtPhys
);
  logic [LOG_REGS-1:0][VW-1:0] logMap;
  logic [VIRT_TAGS-1:0]        bound;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < LOG_REGS; i++) logMap[i] <= VW'(i);
      for (int i = 0; i < VIRT_TAGS; i++) begin
        virtPhys[i] <= (i < LOG_REGS) ? PW'(i) : '0;
        virtAge[i]  <= '0;
        bound[i]    <= (i < LOG_REGS);
        freeV[i]    <= (i >= LOG_REGS);
      end
      for (int i = 0; i < PHYS_REGS; i++) freeP[i] <= (i >= LOG_REGS);
      held <= '0;
    end else begin
      if (stb.cmt) begin
        freeV[stb.cmtOld] <= 1'b1;
        bound[stb.cmtOld] <= 1'b0;
        held[stb.cmtOld]  <= 1'b0;
        held[stb.cmtNew]  <= 1'b0;
        if (bound[stb.cmtOld]) freeP[virtPhys[stb.cmtOld]] <= 1'b1;
      end
      if (stb.allocV) begin
        freeV[stb.allocVtag]  <= 1'b0;
        logMap[stb.allocLog]  <= stb.allocVtag;
        bound[stb.allocVtag]  <= 1'b0;
        held[stb.allocVtag]   <= 1'b0;
      end
      if (stb.steal) begin
        bound[stb.victim] <= 1'b0;
        held[stb.victim]  <= 1'b0;
      end
      if (stb.bindP) begin
        bound[stb.bindVtag]    <= 1'b1;
        held[stb.bindVtag]     <= 1'b1;
        virtPhys[stb.bindVtag] <= stb.bindPhys;
        virtAge[stb.bindVtag]  <= stb.bindAge;
        if (stb.fromFree) freeP[stb.bindPhys] <= 1'b0;
      end
    end
  end

  assign decOldVtag = logMap[decDst];
  assign srcAVtag   = logMap[srcA];
  assign srcBVtag   = logMap[srcB];
  assign srcAReady  = bound[srcAVtag];
  assign srcBReady  = bound[srcBVtag];
  assign srcAPhys   = virtPhys[srcAVtag];
  assign srcBPhys   = virtPhys[srcBVtag];
endmodule

// File: rtl/vp_rename_ctrl.sv
module vp_rename_ctrl
  import vp_rename_pkg::*;
(
  input  logic                      decValid,
  input  logIdx_t                   decDst,
  input  logic                      wbValid,
  input  vtag_t                     wbVtag,
  input  age_t                      wbAge,
  input  age_t                      robHead,
  input  logic [RW-1:0]             rsvCount,
  input  logic                      stealEn,
  input  logic                      cmtValid,
  input  vtag_t                     cmtOldVtag,
  input  vtag_t                     cmtNewVtag,
  input  logic [VIRT_TAGS-1:0]      freeV,
  input  logic [PHYS_REGS-1:0]      freeP,
  input  logic [VIRT_TAGS-1:0]      held,
  input  logic [VIRT_TAGS-1:0][AW-1:0] virtAge,
  input  logic [VIRT_TAGS-1:0][PW-1:0] virtPhys,
  output strobe_t                   stb,
  output vtag_t                     decDstVtag,
  output logic                      decStall,
  output logic                      wbGrant,
  output phys_t                     wbPhys,
  output logic                      wbRetry,
  output logic                      victimValid,
  output vtag_t                     victimVtag,
  output logic [CW-1:0]             freeCount
);
  logic  anyV, anyP, oldest, allowFree, found, useSteal;
  vtag_t pickV, best;
  phys_t pickP;
  age_t  reqRel, bestRel, rel;

  // lowest free virtual tag
  always_comb begin
    anyV  = 1'b0;
    pickV = '0;
    for (int i = VIRT_TAGS - 1; i >= 0; i--)
      if (freeV[i]) begin anyV = 1'b1; pickV = VW'(i); end
  end

  // lowest free physical register and count
  always_comb begin
    anyP      = 1'b0;
    pickP     = '0;
    freeCount = '0;
    for (int i = PHYS_REGS - 1; i >= 0; i--)
      if (freeP[i]) begin
        anyP      = 1'b1;
        pickP     = PW'(i);
        freeCount = freeCount + 1'b1;
      end
  end

  // youngest holder younger than the requester, head-relative
  always_comb begin
    reqRel  = wbAge - robHead;
    found   = 1'b0;
    best    = '0;
    bestRel = '0;
    rel     = '0;
    for (int i = 0; i < VIRT_TAGS; i++) begin
      rel = virtAge[i] - robHead;
      if (held[i] && VW'(i) != wbVtag && !(cmtValid && cmtOldVtag == VW'(i))
          && rel > reqRel && (!found || rel > bestRel)) begin
        found   = 1'b1;
        best    = VW'(i);
        bestRel = rel;
      end
    end
  end

  assign oldest    = (wbAge == robHead);
  assign allowFree = anyP && (oldest || freeCount > CW'(rsvCount));
  assign useSteal  = wbValid && !allowFree && stealEn && found;

  assign decStall    = !anyV;
  assign decDstVtag  = pickV;
  assign wbGrant     = wbValid && (allowFree || useSteal);
  assign wbRetry     = wbValid && !wbGrant;
  assign wbPhys      = allowFree ? pickP : virtPhys[best];
  assign victimValid = useSteal;
  assign victimVtag  = best;

  always_comb begin
    stb           = '0;
    stb.allocV    = decValid && anyV;
    stb.allocVtag = pickV;
    stb.allocLog  = decDst;
    stb.bindP     = wbGrant;
    stb.fromFree  = allowFree;
    stb.bindVtag  = wbVtag;
    stb.bindPhys  = wbPhys;
    stb.bindAge   = wbAge;
    stb.steal     = useSteal;
    stb.victim    = best;
    stb.cmt       = cmtValid;
    stb.cmtOld    = cmtOldVtag;
    stb.cmtNew    = cmtNewVtag;
  end
endmodule

// File: rtl/vp_renamer.sv
module vp_renamer
  import vp_rename_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          decValid,
  input  logic [LW-1:0] decDst,
  input  logic [LW-1:0] srcA,
  input  logic [LW-1:0] srcB,
  output logic [VW-1:0] decDstVtag,
  output logic [VW-1:0] decOldVtag,
  output logic          decStall,
  output logic [VW-1:0] srcAVtag,
  output logic          srcAReady,
  output logic [PW-1:0] srcAPhys,
  output logic [VW-1:0] srcBVtag,
  output logic          srcBReady,
  output logic [PW-1:0] srcBPhys,
  input  logic          wbValid,
  input  logic [VW-1:0] wbVtag,
  input  logic [AW-1:0] wbAge,
  input  logic [AW-1:0] robHead,
  input  logic [RW-1:0] rsvCount,
  input  logic          stealEn,
  output logic          wbGrant,
  output logic [PW-1:0] wbPhys,
  output logic          wbRetry,
  output logic          victimValid,
  output logic [VW-1:0] victimVtag,
  input  logic          cmtValid,
  input  logic [VW-1:0] cmtOldVtag,
  input  logic [VW-1:0] cmtNewVtag
);
  strobe_t                     stb;
  logic [VIRT_TAGS-1:0]        freeV, held;
  logic [PHYS_REGS-1:0]        freeP;
  logic [VIRT_TAGS-1:0][AW-1:0] virtAge;
  logic [VIRT_TAGS-1:0][PW-1:0] virtPhys;
  logic [CW-1:0]               freeCount;

  vp_rename_ctrl u_ctrl (
    .decValid, .decDst, .wbValid, .wbVtag, .wbAge, .robHead, .rsvCount,
    .stealEn, .cmtValid, .cmtOldVtag, .cmtNewVtag, .freeV, .freeP, .held,
    .virtAge, .virtPhys, .stb, .decDstVtag, .decStall, .wbGrant, .wbPhys,
    .wbRetry, .victimValid, .victimVtag, .freeCount
  );

  vp_rename_dp u_dp (
    .clk, .rstN, .stb, .decDst, .srcA, .srcB, .decOldVtag, .srcAVtag,
    .srcAReady, .srcAPhys, .srcBVtag, .srcBReady, .srcBPhys, .freeV,
    .freeP, .held, .virtAge, .virtPhys
  );
endmodule

// File: rtl/vp_renamer_chk.sv
module vp_renamer_chk
  import vp_rename_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 decValid,
  input logic                 decStall,
  input logic [VW-1:0]        decDstVtag,
  input logic                 wbValid,
  input logic                 wbGrant,
  input logic                 wbRetry,
  input logic [PW-1:0]        wbPhys,
  input logic [AW-1:0]        wbAge,
  input logic [AW-1:0]        robHead,
  input logic [RW-1:0]        rsvCount,
  input logic                 stealEn,
  input logic                 victimValid,
  input logic [VW-1:0]        victimVtag,
  input logic                 cmtValid,
  input logic [VW-1:0]        cmtOldVtag,
  input logic [VIRT_TAGS-1:0] freeV,
  input logic [PHYS_REGS-1:0] freeP,
  input logic [CW-1:0]        freeCount
);
  // R2
  dec_takes_tag_chk: assert property (@(posedge clk) disable iff (!rstN)
    decValid && !decStall |=> !freeV[$past(decDstVtag)]);
  // R4
  grant_from_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbGrant && !victimValid |-> freeP[wbPhys]);
  // R5
  reserve_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbGrant && !victimValid && wbAge != robHead |-> freeCount > CW'(rsvCount));
  // R6
  grant_or_retry_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> (wbGrant != wbRetry));
  // R7
  steal_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    victimValid |-> wbGrant && stealEn);
  // R9
  commit_frees_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmtValid |=> freeV[$past(cmtOldVtag)]);
  // R10
  no_steal_committed_chk: assert property (@(posedge clk) disable iff (!rstN)
    victimValid && cmtValid |-> victimVtag != cmtOldVtag);
endmodule

bind vp_renamer vp_renamer_chk u_chk (
  .clk(clk), .rstN(rstN), .decValid(decValid), .decStall(decStall),
  .decDstVtag(decDstVtag), .wbValid(wbValid), .wbGrant(wbGrant),
  .wbRetry(wbRetry), .wbPhys(wbPhys), .wbAge(wbAge), .robHead(robHead),
  .rsvCount(rsvCount), .stealEn(stealEn), .victimValid(victimValid),
  .victimVtag(victimVtag), .cmtValid(cmtValid), .cmtOldVtag(cmtOldVtag),
  .freeV(freeV), .freeP(freeP), .freeCount(freeCount)
);

// File: tb/vp_renamer_tb.sv
`timescale 1ns/1ps
module vp_renamer_tb;
  logic       clk = 1'b0;
  logic       rstN;
  logic       decValid;
  logic [4:0] decDst, srcA, srcB;
  logic [5:0] decDstVtag, decOldVtag, srcAVtag, srcBVtag;
  logic       decStall, srcAReady, srcBReady;
  logic [5:0] srcAPhys, srcBPhys;
  logic       wbValid;
  logic [5:0] wbVtag, wbAge, robHead;
  logic [3:0] rsvCount;
  logic       stealEn, wbGrant, wbRetry, victimValid;
  logic [5:0] wbPhys, victimVtag;
  logic       cmtValid;
  logic [5:0] cmtOldVtag, cmtNewVtag;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  vp_renamer u_dut (.*);

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr();
    decValid = 0; decDst = 0; srcA = 0; srcB = 0;
    wbValid = 0; wbVtag = 0; wbAge = 0; stealEn = 0;
    cmtValid = 0; cmtOldVtag = 0; cmtNewVtag = 0;
  endtask

  task automatic cyc();
    @(negedge clk);
    clr();
  endtask

  task automatic wb(int vt, int age, int head, bit st);
    wbValid = 1; wbVtag = 6'(vt); wbAge = 6'(age); robHead = 6'(head); stealEn = st;
    #1;
  endtask

  initial begin
    #(5.0 * 20000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rstN = 0; robHead = 0; rsvCount = 2;
    clr();
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;

    // R1: identity mapping, bound and ready
    for (int i = 0; i < 32; i++) begin
      cyc(); srcA = 5'(i); srcB = 5'(31 - i); #1;
      check("R1 srcA vtag", srcAVtag, i);
      check("R1 srcA ready", srcAReady, 1);
      check("R1 srcA phys", srcAPhys, i);
      check("R1 srcB vtag", srcBVtag, 31 - i);
    end

    // R2: destinations take lowest free tags 32..63
    for (int k = 0; k < 32; k++) begin
      cyc(); decValid = 1; decDst = 5'(k); #1;
      check("R2 dst vtag", decDstVtag, 32 + k);
      check("R2 old vtag", decOldVtag, k);
      check("R2 no stall", decStall, 0);
    end
    for (int k = 0; k < 32; k++) begin
      cyc(); srcA = 5'(k); #1;
      check("R2 src new vtag", srcAVtag, 32 + k);
      check("R2 src not ready", srcAReady, 0);
    end

    // R3: no free tag
    cyc(); decValid = 1; decDst = 5; #1;
    check("R3 stall", decStall, 1);
    cyc(); srcA = 5; #1;
    check("R3 map kept", srcAVtag, 37);

    // R4/R5: 14 younger writers drain free list down to the reserve
    for (int j = 0; j < 14; j++) begin
      cyc(); wb(32 + j, 40 + j, 0, 0);
      check("R4 grant", wbGrant, 1);
      check("R4 lowest phys", wbPhys, 32 + j);
    end
    cyc(); wb(46, 60, 0, 0);
    check("R5 reserve denies younger", wbGrant, 0);
    check("R6 retry", wbRetry, 1);
    cyc(); wb(46, 0, 0, 0);
    check("R5 oldest uses reserve", wbGrant, 1);
    check("R5 oldest phys", wbPhys, 46);
    cyc(); wb(47, 1, 1, 0);
    check("R5 oldest second", wbGrant, 1);
    check("R5 oldest phys2", wbPhys, 47);
    cyc(); srcA = 0; srcB = 13; #1;
    check("R4 ready after bind", srcAReady, 1);
    check("R4 bound phys", srcAPhys, 32);
    check("R4 bound phys B", srcBPhys, 45);

    // R7: steal from youngest younger holder (vtag 45, age 53)
    cyc(); wb(48, 45, 0, 1);
    check("R7 grant", wbGrant, 1);
    check("R7 victim valid", victimValid, 1);
    check("R7 victim tag", victimVtag, 45);
    check("R7 stolen phys", wbPhys, 45);
    cyc(); srcA = 13; srcB = 16; #1;
    check("R7 victim not ready", srcAReady, 0);
    check("R7 thief ready", srcBReady, 1);
    check("R7 thief phys", srcBPhys, 45);
    cyc(); wb(49, 53, 0, 1);
    check("R6 no victim retry", wbRetry, 1);
    check("R6 no victim flag", victimValid, 0);

    // R8: head 40, vtag 47 (age 1) is youngest after wrap
    cyc(); wb(49, 40, 40, 1);
    check("R8 victim after wrap", victimVtag, 47);
    check("R8 phys", wbPhys, 47);

    // R9: commit frees vtag 1 and phys 1
    cyc(); cmtValid = 1; cmtOldVtag = 1; cmtNewVtag = 33; #1;
    cyc(); decValid = 1; decDst = 1; #1;
    check("R9 freed vtag reused", decDstVtag, 1);
    check("R9 old vtag", decOldVtag, 33);
    cyc(); wb(47, 40, 40, 0); srcA = 1; #1;
    check("R9 freed phys reused", wbPhys, 1);
    check("R9 grant", wbGrant, 1);
    check("R2 renamed src not ready", srcAReady, 0);

    // R10: only candidate (vtag 44) is committed in the same cycle
    cyc(); wb(50, 51, 0, 1); cmtValid = 1; cmtOldVtag = 44; cmtNewVtag = 34; #1;
    check("R10 retry", wbRetry, 1);
    check("R10 no victim", victimValid, 0);
    // decode and write-back together take what the commit freed
    cyc(); wb(50, 0, 0, 0); decValid = 1; decDst = 2; #1;
    check("R9 phys 44 reused", wbPhys, 44);
    check("R9 vtag 44 reused", decDstVtag, 44);
    check("R9 old of r2", decOldVtag, 34);
    cyc(); srcA = 18; #1;
    check("R4 tag 50 bound", srcAPhys, 44);
    check("R4 tag 50 ready", srcAReady, 1);

    cyc();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule